// File: doc/BRIEF.md
# Dual-Subcarrier Manchester Uplink Encoder

This block drives the load-modulation control of a contactless tag while it answers a reader. It runs from a clock at the carrier frequency fc and takes payload bytes over a valid/ready stream. After a start strobe it sends a start-of-frame pattern, then each byte as Manchester-coded bits, least significant bit first. An end-of-frame pattern closes the frame. CRC bytes are produced upstream and arrive as ordinary payload. The analog load switch sits outside the block.

Every symbol is built from whole subcarrier periods. Tone A is fc/32, which is 16 clocks high and 16 clocks low. Tone B is fc/28, which is 14 high and 14 low. In single-subcarrier mode the other half of each symbol is unmodulated carrier. In dual-subcarrier mode it is a burst of tone B. At low data rate every segment length is four times the high-rate length and the tones stay the same. Each segment starts at the high phase, so the two tones join without a phase break. The `sub_sel` output tells the analog side which tone is being keyed.

Top module: `uplink_manchester_enc`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `mod_out`, `sub_sel` and `in_ready` are all 0.
- R2: A `start` seen while idle raises `busy` at that clock edge. Sample 0 of the frame appears on `mod_out` one edge later. A `start` while `busy` is 1 has no effect on the frame.
- R3: A tone-A segment of length L clocks reads on `mod_out` as 1 for offsets where (offset/16) is even and 0 otherwise. Tone B uses 14 in place of 16. An unmodulated segment reads 0. `sub_sel` is 1 exactly for the samples that belong to tone-B segments.
- R4: Single-subcarrier mode (`dual_sc`=0). A 0 bit is 256 clocks of tone A followed by 256 clocks unmodulated. A 1 bit is the same two segments in the opposite order.
- R5: Dual-subcarrier mode (`dual_sc`=1). A 0 bit is 256 clocks of tone A followed by 252 clocks of tone B. A 1 bit is tone B 252 followed by tone A 256.
- R6: The start pattern in single mode is 768 clocks unmodulated, then tone A for 768, then a 1 bit. In dual mode it is tone B for 756, then tone A for 768, then a 1 bit.
- R7: The end pattern in single mode is a 0 bit, then tone A for 768, then 768 unmodulated. In dual mode it is a 0 bit, then tone A for 768, then tone B for 756.
- R8: With `high_rate`=0, every segment of R4 to R7 is four times as long and uses the same tones.
- R9: Bytes go out in the order they are accepted, bit 0 first. A byte taken with `in_last`=1 is followed directly by the end pattern.
- R10: `in_ready` is 1 only during the final bit of the start pattern, or during bit 7 of a byte not marked last, and only while no byte is already held. Exactly one byte is accepted per byte slot.
- R11: If no byte has been accepted when the current byte or start pattern ends, the end pattern follows at once. With no bytes at all, the frame is the start pattern followed by the end pattern.
- R12: `dual_sc` and `high_rate` are sampled only with an accepted `start`. Changes to them during a frame have no effect.
- R13: `busy` falls at the same edge that puts the last end-pattern sample on `mod_out`. The next sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock (fc) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame when idle |
| dual_sc | input | 1 | 1 = two subcarriers, 0 = one subcarrier |
| high_rate | input | 1 | 1 = high data rate, 0 = low (x4 lengths) |
| in_valid | input | 1 | Payload byte available |
| in_data | input | DW | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| busy | output | 1 | Frame in progress |
| mod_out | output | 1 | Registered load-modulation level |
| sub_sel | output | 1 | Registered: 1 while tone B (fc/28) is keyed |

## Verification
The embedded properties check on every cycle that the output stays quiet while idle and that a start leads to busy. They also check that the mode captured for a frame never changes while it runs, that the subcarrier half-period counter stays in range, and that a handshake never gets a second ready before the held byte is consumed. The exact symbol shapes, segment lengths, bit order, rate scaling, underrun ending and the edge where busy falls can only be shown by the bench. It rebuilds each frame's waveform arithmetically and compares every output sample over single and dual modes, both rates, empty and underrun frames, and a frame disturbed by mode changes and a stray start.

// File: rtl/uplink_enc_pkg.sv
package uplink_enc_pkg;
  typedef enum logic [1:0] {
    TONE_OFF = 2'd0,
    TONE_A   = 2'd1,
    TONE_B   = 2'd2
  } tone_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOF  = 2'd1,
    ST_DATA = 2'd2,
    ST_EOF  = 2'd3
  } frm_st_e;
endpackage

// File: rtl/uplink_subcarrier.sv
module uplink_subcarrier
  import uplink_enc_pkg::*;
#(
  parameter int HALF_A = 16,
  parameter int HALF_B = 14
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  active,
  input  logic  seg_last,
  input  tone_e tone,
  output logic  level
);
  localparam int HMAX = (HALF_A > HALF_B) ? HALF_A : HALF_B;
  localparam int HW   = $clog2(HMAX + 1);

  logic [HW-1:0] hcnt;
  logic          ph;
  logic [HW-1:0] half_m1;

  always_comb begin
    half_m1 = (tone == TONE_B) ? HW'(HALF_B - 1) : HW'(HALF_A - 1);
    level   = ph && (tone != TONE_OFF);
  end

  // every segment holds whole periods, so restarting at the high phase keeps tones continuous
  always_ff @(posedge clk) begin
    if (rst || !active || seg_last) begin
      hcnt <= '0;
      ph   <= 1'b1;
    end else if (hcnt == half_m1) begin
      hcnt <= '0;
      ph   <= ~ph;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  p_half_bound_r3: assert property (@(posedge clk) disable iff (rst)
    hcnt < HW'(HMAX));
endmodule

// File: rtl/uplink_frame_seq.sv
module uplink_frame_seq
  import uplink_enc_pkg::*;
#(
  parameter int DW            = 8,
  parameter int HALF_A        = 16,
  parameter int HALF_B        = 14,
  parameter int BIT_PULSES_A  = 8,
  parameter int BIT_PULSES_B  = 9,
  parameter int LONG_PULSES_A = 24,
  parameter int LONG_PULSES_B = 27,
  parameter int LOW_MULT      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dual_sc,
  input  logic          high_rate,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          busy,
  output tone_e         tone,
  output logic          seg_last
);
  localparam int LEN_A_BIT  = BIT_PULSES_A * 2 * HALF_A;
  localparam int LEN_B_BIT  = BIT_PULSES_B * 2 * HALF_B;
  localparam int LEN_A_LONG = LONG_PULSES_A * 2 * HALF_A;
  localparam int LEN_B_LONG = LONG_PULSES_B * 2 * HALF_B;
  localparam int LEN_MAXB   = (LEN_A_LONG > LEN_B_LONG) ? LEN_A_LONG : LEN_B_LONG;
  localparam int CW         = $clog2(LEN_MAXB * LOW_MULT + 1);
  localparam int BW         = (DW > 1) ? $clog2(DW) : 1;

  frm_st_e       st;
  logic [1:0]    part;
  logic [CW-1:0] seg_cnt;
  logic [CW-1:0] base;
  logic [CW-1:0] seg_len;
  logic          dual_q, low_q;
  logic [DW-1:0] shreg;
  logic [BW-1:0] bitn;
  logic          cur_last;
  logic [DW-1:0] nxt_buf;
  logic          nxt_full, nxt_last;

  tone_e         alt;
  logic [CW-1:0] alt_s, alt_l;
  logic          final_bit, fire, load_ok, load_last;
  logic [DW-1:0] load_byte;

  always_comb begin
    alt   = dual_q ? TONE_B : TONE_OFF;
    alt_s = dual_q ? CW'(LEN_B_BIT)  : CW'(LEN_A_BIT);
    alt_l = dual_q ? CW'(LEN_B_LONG) : CW'(LEN_A_LONG);
    tone  = TONE_OFF;
    base  = CW'(LEN_A_BIT);
    case (st)
      ST_SOF: begin
        case (part)
          2'd0:    begin tone = alt;    base = alt_l;             end
          2'd1:    begin tone = TONE_A; base = CW'(LEN_A_LONG);   end
          2'd2:    begin tone = alt;    base = alt_s;             end
          default: begin tone = TONE_A; base = CW'(LEN_A_BIT);    end
        endcase
      end
      ST_EOF: begin
        case (part)
          2'd0:    begin tone = TONE_A; base = CW'(LEN_A_BIT);    end
          2'd1:    begin tone = alt;    base = alt_s;             end
          2'd2:    begin tone = TONE_A; base = CW'(LEN_A_LONG);   end
          default: begin tone = alt;    base = alt_l;             end
        endcase
      end
      ST_DATA: begin
        if ((part == 2'd0) == shreg[0]) begin
          tone = alt;    base = alt_s;
        end else begin
          tone = TONE_A; base = CW'(LEN_A_BIT);
        end
      end
      default: begin
        tone = TONE_OFF; base = CW'(LEN_A_BIT);
      end
    endcase
    seg_len   = low_q ? CW'(32'(base) * LOW_MULT) : base;
    busy      = (st != ST_IDLE);
    seg_last  = busy && (seg_cnt == seg_len - 1'b1);
    final_bit = ((st == ST_SOF) && part[1]) ||
                ((st == ST_DATA) && (bitn == BW'(DW - 1)) && !cur_last);
    in_ready  = final_bit && !nxt_full;
    fire      = in_valid && in_ready;
    load_ok   = nxt_full || fire;
    load_byte = nxt_full ? nxt_buf  : in_data;
    load_last = nxt_full ? nxt_last : in_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      part     <= '0;
      seg_cnt  <= '0;
      dual_q   <= 1'b0;
      low_q    <= 1'b0;
      shreg    <= '0;
      bitn     <= '0;
      cur_last <= 1'b0;
      nxt_buf  <= '0;
      nxt_full <= 1'b0;
      nxt_last <= 1'b0;
    end else begin
      if (fire) begin
        nxt_buf  <= in_data;
        nxt_last <= in_last;
        nxt_full <= 1'b1;
      end
      if (st == ST_IDLE) begin
        if (start) begin
          st       <= ST_SOF;
          part     <= '0;
          seg_cnt  <= '0;
          dual_q   <= dual_sc;
          low_q    <= !high_rate;
          nxt_full <= 1'b0;
        end
      end else if (!seg_last) begin
        seg_cnt <= seg_cnt + 1'b1;
      end else begin
        seg_cnt <= '0;
        case (st)
          ST_SOF: begin
            if (part != 2'd3) begin
              part <= part + 2'd1;
            end else if (load_ok) begin
              st       <= ST_DATA;
              part     <= '0;
              shreg    <= load_byte;
              bitn     <= '0;
              cur_last <= load_last;
              nxt_full <= 1'b0;
            end else begin
              st   <= ST_EOF;
              part <= '0;
            end
          end
          ST_DATA: begin
            if (part == 2'd0) begin
              part <= 2'd1;
            end else if (bitn != BW'(DW - 1)) begin
              part  <= '0;
              bitn  <= bitn + 1'b1;
              shreg <= shreg >> 1;
            end else if (!cur_last && load_ok) begin
              part     <= '0;
              shreg    <= load_byte;
              bitn     <= '0;
              cur_last <= load_last;
              nxt_full <= 1'b0;
            end else begin
              st   <= ST_EOF;
              part <= '0;
            end
          end
          default: begin
            if (part != 2'd3) part <= part + 2'd1;
            else              st   <= ST_IDLE;
          end
        endcase
      end
    end
  end

  // R10: once a byte is taken, ready stays low until it has been consumed
  p_one_byte_r10: assert property (@(posedge clk) disable iff (rst)
    fire |=> !in_ready);

  // R12: mode captured at start stays fixed while the frame runs
  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(dual_q) && $stable(low_q)));

  // R13: the segment counter never passes the length of the current segment
  p_cnt_bound_r13: assert property (@(posedge clk) disable iff (rst)
    busy |-> (seg_cnt < seg_len));
endmodule

// File: rtl/uplink_manchester_enc.sv
module uplink_manchester_enc
  import uplink_enc_pkg::*;
#(
  parameter int DW            = 8,
  parameter int HALF_A        = 16,
  parameter int HALF_B        = 14,
  parameter int BIT_PULSES_A  = 8,
  parameter int BIT_PULSES_B  = 9,
  parameter int LONG_PULSES_A = 24,
  parameter int LONG_PULSES_B = 27,
  parameter int LOW_MULT      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dual_sc,
  input  logic          high_rate,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          busy,
  output logic          mod_out,
  output logic          sub_sel
);
  tone_e tone;
  logic  seg_last;
  logic  level;

  uplink_frame_seq #(
    .DW(DW), .HALF_A(HALF_A), .HALF_B(HALF_B),
    .BIT_PULSES_A(BIT_PULSES_A), .BIT_PULSES_B(BIT_PULSES_B),
    .LONG_PULSES_A(LONG_PULSES_A), .LONG_PULSES_B(LONG_PULSES_B),
    .LOW_MULT(LOW_MULT)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .dual_sc(dual_sc),
    .high_rate(high_rate), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .busy(busy),
    .tone(tone), .seg_last(seg_last)
  );

  uplink_subcarrier #(.HALF_A(HALF_A), .HALF_B(HALF_B)) u_sc (
    .clk(clk), .rst(rst), .active(busy), .seg_last(seg_last),
    .tone(tone), .level(level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_out <= 1'b0;
      sub_sel <= 1'b0;
    end else begin
      mod_out <= busy && level;
      sub_sel <= busy && (tone == TONE_B);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (!mod_out && !sub_sel));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: tb/tb_uplink_manchester_enc.sv
`timescale 1ns/1ps
module tb_uplink_manchester_enc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, dual_sc = 1'b0, high_rate = 1'b1;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, busy, mod_out, sub_sel;

  always #5 clk = ~clk;

  uplink_manchester_enc dut (
    .clk(clk), .rst(rst), .start(start), .dual_sc(dual_sc),
    .high_rate(high_rate), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .busy(busy),
    .mod_out(mod_out), .sub_sel(sub_sel)
  );

  int checks = 0, errors = 0, cyc = 0;

  int seg_tone [0:63];
  int seg_len  [0:63];
  int seg_beg  [0:63];
  bit seg_win  [0:63];
  int nseg = 0, total = 0;

  logic [7:0] fbytes [0:3];
  int  prov_n = 0, frame_no = 0;
  bit  prov_lastmark = 1'b0;
  int  prov_idx = 0, seen_no = 0;
  bit  pend = 1'b0;

  // byte provider: advances after each accepted handshake
  always @(negedge clk) begin
    if (seen_no != frame_no) begin
      seen_no  = frame_no;
      prov_idx = 0;
      pend     = 1'b0;
    end
    if (pend) prov_idx++;
    in_valid = (prov_idx < prov_n);
    in_data  = (prov_idx < 4) ? fbytes[prov_idx] : 8'h00;
    in_last  = prov_lastmark && (prov_idx == prov_n - 1);
    pend     = in_valid && in_ready;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add(int t, int l, bit w);
    seg_tone[nseg] = t;
    seg_len[nseg]  = l;
    seg_beg[nseg]  = total;
    seg_win[nseg]  = w;
    total += l;
    nseg++;
  endtask

  task automatic build(bit dual, bit high, int nb, bit lastmark);
    int m, alt, als, all;
    m   = high ? 1 : 4;
    alt = dual ? 2 : 0;
    als = dual ? 252 : 256;
    all = dual ? 756 : 768;
    nseg = 0; total = 0;
    add(alt, all * m, 0); add(1, 768 * m, 0);
    add(alt, als * m, 1); add(1, 256 * m, 1);
    for (int b = 0; b < nb; b++) begin
      for (int i = 0; i < 8; i++) begin
        bit w;
        w = (i == 7) && !(b == nb - 1 && lastmark);
        if (fbytes[b][i]) begin
          add(alt, als * m, w); add(1, 256 * m, w);
        end else begin
          add(1, 256 * m, w); add(alt, als * m, w);
        end
      end
    end
    add(1, 256 * m, 0); add(alt, als * m, 0);
    add(1, 768 * m, 0); add(alt, all * m, 0);
  endtask

  function automatic int seg_of(int off);
    for (int s = 0; s < nseg; s++)
      if (off >= seg_beg[s] && off < seg_beg[s] + seg_len[s]) return s;
    return nseg - 1;
  endfunction

  function automatic bit exp_mod(int off);
    int s, h;
    s = seg_of(off);
    h = (seg_tone[s] == 2) ? 14 : 16;
    return (seg_tone[s] != 0) && ((((off - seg_beg[s]) / h) % 2) == 0);
  endfunction

  task automatic run_frame(string rq_wave, bit dual, bit high, int nb, bit lastmark,
                           logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, bit disturb);
    int bad_mod = 0, bad_sub = 0, bad_busy = 0, bad_rdy = 0;
    int fj_mod = -1, fj_sub = -1, fj_busy = -1;
    fbytes[0] = b0; fbytes[1] = b1; fbytes[2] = b2; fbytes[3] = 8'h00;
    build(dual, high, nb, lastmark);
    prov_n = nb; prov_lastmark = lastmark; frame_no++;
    @(negedge clk);
    start = 1'b1; dual_sc = dual; high_rate = high;
    @(posedge clk); #1 start = 1'b0;
    for (int j = 1; j <= total + 1; j++) begin
      @(posedge clk); #1;
      if (j <= total) begin
        if (mod_out !== exp_mod(j - 1)) begin bad_mod++; if (fj_mod < 0) fj_mod = j - 1; end
        if (sub_sel !== (seg_tone[seg_of(j - 1)] == 2)) begin bad_sub++; if (fj_sub < 0) fj_sub = j - 1; end
        if (busy !== (j < total)) begin bad_busy++; if (fj_busy < 0) fj_busy = j; end
        if (j < total && in_ready && !seg_win[seg_of(j)]) bad_rdy++;
      end
      if (disturb && j == 200) begin
        dual_sc = ~dual; high_rate = ~high; start = 1'b1;
      end
      if (disturb && j == 201) start = 1'b0;
    end
    chk(bad_mod == 0, {rq_wave, " R3 mod_out waveform mismatches / first offset"}, fj_mod, -1);
    chk(bad_sub == 0, "R3 sub_sel marks tone B segments / first offset", fj_sub, -1);
    chk(bad_busy == 0, "R2 R13 busy span / first mismatch index", fj_busy, -1);
    chk(bad_rdy == 0, "R10 in_ready outside final-bit window count", bad_rdy, 0);
    chk(prov_idx == nb, "R9 R10 bytes accepted per frame", prov_idx, nb);
    chk(mod_out == 1'b0 && sub_sel == 1'b0 && busy == 1'b0, "R1 R13 idle after frame",
        {mod_out, sub_sel, busy}, 0);
    dual_sc = 1'b0; high_rate = 1'b1;
    prov_n = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk(busy == 0 && mod_out == 0 && sub_sel == 0 && in_ready == 0,
        "R1 reset state", {busy, mod_out, sub_sel, in_ready}, 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(busy == 0 && mod_out == 0, "R1 idle without start", {busy, mod_out}, 0);
    // single subcarrier, high rate, two bytes
    run_frame("R4 R6 R7 R9", 1'b0, 1'b1, 2, 1'b1, 8'hA5, 8'h3C, 8'h00, 1'b0);
    // dual subcarrier, high rate, three bytes
    run_frame("R5 R6 R7 R9", 1'b1, 1'b1, 3, 1'b1, 8'h01, 8'h80, 8'hFF, 1'b0);
    // low rate, single then dual
    run_frame("R8 R4", 1'b0, 1'b0, 1, 1'b1, 8'h5A, 8'h00, 8'h00, 1'b0);
    run_frame("R8 R5", 1'b1, 1'b0, 1, 1'b1, 8'hC3, 8'h00, 8'h00, 1'b0);
    // empty frame and mid-frame underrun
    run_frame("R11 R6 R7", 1'b1, 1'b1, 0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0);
    run_frame("R11 R4", 1'b0, 1'b1, 1, 1'b0, 8'h96, 8'h00, 8'h00, 1'b0);
    // mode inputs flipped and stray start during the frame
    run_frame("R12 R2 R5", 1'b1, 1'b1, 2, 1'b1, 8'h0F, 8'hE1, 8'h00, 1'b1);
    summary();
    $finish;
  end
endmodule